// File: doc/BRIEF.md
# Vectored Interrupt Priority Core

This block keeps the state of 256 interrupt vectors in three bit arrays: pending requests, vectors currently in service, and a per-vector trigger flag (level or edge). A source posts a vector together with its trigger type. The block then derives a processor priority from the task priority register and from the most important vector already in service. It raises an interrupt line to the core whenever a pending request outranks that priority by 16-vector class.

When the core acknowledges, the winning vector moves from the request array to the in-service array and is presented on the acknowledge vector output. If the top request is held back by priority, the acknowledge instead returns the spurious vector held in the low byte of the spurious-vector register and changes nothing. An end-of-interrupt strobe retires the highest in-service vector. When that vector was level-triggered, the block emits a one-cycle broadcast pulse carrying the vector number so that upstream level sources can re-evaluate.

Top module: `vec_prio_core`

## Requirements
- R1: After reset all three arrays, the task priority and the spurious-vector register are zero. irq_o, eoi_bcast_o and ack_vec_o read 0, and a posted vector does not raise irq_o because the block is software-disabled.
- R2: A post of vector v sets request bit v. The trigger flag of v becomes 1 when post_level_i is 1 (level) and 0 when it is 0 (edge).
- R3: Among pending requests, the winner is the highest-numbered set bit, and ack_vec_o shows that vector during an accepted acknowledge.
- R4: The processor priority equals tpr when tpr[7:4] is at least the class (bits 7:4) of the top in-service vector. Otherwise it is that class followed by four zero bits. An empty in-service array counts as class 0.
- R5: A top request is blocked when the processor priority is nonzero and the request class is less than or equal to the processor priority class. While it is blocked, irq_o is low, and an acknowledge returns svr[7:0] and changes no state.
- R6: While svr bit 8 (software enable) is 0, irq_o stays low and an acknowledge moves no vector.
- R7: An acknowledge with an unblocked request clears that request bit and sets the same in-service bit.
- R8: An EOI clears the highest set in-service bit.
- R9: If the retired vector has its trigger flag set and svr bit 12 (directed EOI) is 0, eoi_bcast_o is 1 for exactly the cycle after the EOI, with eoi_vec_o equal to the vector. An edge vector gives no pulse.
- R10: An EOI with an empty in-service array changes no state and gives no pulse.
- R11: A spurious-vector write keeps only bits 8:0. A written bit 12 is therefore dropped, and level vectors still broadcast on EOI.
- R12: When a post and an accepted acknowledge name the same vector in one cycle, the request bit stays set and the in-service bit is also set.
- R13: irq_o is derived combinationally from registered state and follows a state-changing write in the cycle right after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| post_i | input | 1 | Post a vector this cycle |
| post_vec_i | input | 8 | Vector being posted |
| post_level_i | input | 1 | 1 = level-triggered post, 0 = edge |
| tpr_we_i | input | 1 | Task priority write strobe |
| tpr_i | input | 8 | Task priority write data |
| svr_we_i | input | 1 | Spurious-vector register write strobe |
| svr_i | input | 16 | Spurious-vector register write data |
| ack_i | input | 1 | Acknowledge strobe from the core |
| eoi_i | input | 1 | End-of-interrupt strobe |
| irq_o | output | 1 | Unblocked request pending and enabled |
| ack_vec_o | output | 8 | Winning vector, or svr[7:0] when none is deliverable |
| eoi_bcast_o | output | 1 | One-cycle pulse after EOI of a level vector |
| eoi_vec_o | output | 8 | Vector carried by the broadcast pulse |

## Verification
Every vector from 0 to 255 is posted alone, acknowledged and retired, alternating level and edge triggers. This separates the vector search, the array move and the broadcast condition at every bit position. A second sweep crosses every task priority class, with low nibble zero and nonzero, against a request in every class. It tells apart the "less than or equal" class rule, the nonzero-priority exception and the spurious return. Directed patterns stack several requests to expose winner order, nest in-service vectors so that the processor priority comes from the in-service side, and cover disabled operation, a dropped directed-EOI bit, an EOI on an empty array and a post colliding with an acknowledge.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  localparam int SVR_EN_BIT  = 8;
  localparam int SVR_DIR_BIT = 12;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;
endpackage

// File: rtl/vpc_find_top.sv
// Highest set bit of a wide vector, split into per-group search plus group pick.
module vpc_find_top #(
  parameter int WIDTH   = 256,
  parameter int GROUP_W = 16,
  localparam int IDX_W  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] bits_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam int NGRP  = WIDTH / GROUP_W;
  localparam int LOC_W = $clog2(GROUP_W);
  localparam int GRP_W = IDX_W - LOC_W;

  logic [NGRP-1:0]       grp_any;
  logic [NGRP*LOC_W-1:0] grp_loc;
  logic [GRP_W-1:0]      sel_grp;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [GROUP_W-1:0] slice;
    logic [LOC_W-1:0]   loc;
    assign slice      = bits_i[g*GROUP_W +: GROUP_W];
    assign grp_any[g] = |slice;
    always_comb begin
      loc = '0;
      for (int b = 0; b < GROUP_W; b++) begin
        if (slice[b]) loc = LOC_W'(b);
      end
    end
    assign grp_loc[g*LOC_W +: LOC_W] = loc;
  end

  always_comb begin
    sel_grp = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (grp_any[g]) sel_grp = GRP_W'(g);
    end
  end

  assign any_o = |grp_any;
  assign idx_o = {sel_grp, grp_loc[sel_grp*LOC_W +: LOC_W]};
endmodule

// File: rtl/vpc_prio_calc.sv
// Processor priority and class-based blocking of the top request.
module vpc_prio_calc #(
  parameter int VEC_W  = 8,
  parameter int SUB_W  = 4,
  localparam int CLS_W = VEC_W - SUB_W
) (
  input  logic             enable_i,
  input  logic [VEC_W-1:0] tpr_i,
  input  logic             isr_any_i,
  input  logic [CLS_W-1:0] isr_cls_i,
  input  logic             irr_any_i,
  input  logic [CLS_W-1:0] irr_cls_i,
  output logic [VEC_W-1:0] ppr_o,
  output logic             blocked_o,
  output logic             pending_o
);
  logic [CLS_W-1:0] svc_cls;
  logic [CLS_W-1:0] tpr_cls;
  logic [CLS_W-1:0] ppr_cls;

  assign svc_cls = isr_any_i ? isr_cls_i : '0;
  assign tpr_cls = tpr_i[VEC_W-1 -: CLS_W];
  assign ppr_o   = (tpr_cls >= svc_cls) ? tpr_i : {svc_cls, {SUB_W{1'b0}}};
  assign ppr_cls = ppr_o[VEC_W-1 -: CLS_W];

  assign blocked_o = irr_any_i && (ppr_o != '0) && (irr_cls_i <= ppr_cls);
  assign pending_o = enable_i && irr_any_i && !blocked_o;
endmodule

// File: rtl/vec_prio_core.sv
module vec_prio_core
  import vpc_pkg::*;
#(
  parameter int NUM_VEC    = 256,
  parameter int SUB_W      = 4,
  parameter int SVR_W      = 16,
  parameter int SVR_KEEP_W = 9,
  localparam int VEC_W     = $clog2(NUM_VEC),
  localparam int CLS_W     = VEC_W - SUB_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             post_i,
  input  logic [VEC_W-1:0] post_vec_i,
  input  logic             post_level_i,
  input  logic             tpr_we_i,
  input  logic [VEC_W-1:0] tpr_i,
  input  logic             svr_we_i,
  input  logic [SVR_W-1:0] svr_i,
  input  logic             ack_i,
  input  logic             eoi_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] ack_vec_o,
  output logic             eoi_bcast_o,
  output logic [VEC_W-1:0] eoi_vec_o
);
  localparam logic [SVR_W-1:0] KEEP_MASK = SVR_W'((1 << SVR_KEEP_W) - 1);
  localparam logic [SVR_W-1:0] EN_MASK   = SVR_W'(1 << SVR_EN_BIT);
  localparam logic [SVR_W-1:0] DIR_MASK  = SVR_W'(1 << SVR_DIR_BIT);
  localparam int GROUP_W = 1 << SUB_W;

  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
  logic [NUM_VEC-1:0] irr_d, isr_d, tmr_d;
  logic [VEC_W-1:0]   tpr_q;
  logic [SVR_W-1:0]   svr_q;
  logic               bcast_q;
  logic [VEC_W-1:0]   bcast_vec_q;

  logic               irr_any, isr_any;
  logic [VEC_W-1:0]   irr_top, isr_top;
  logic [VEC_W-1:0]   ppr;
  logic               blocked, pending;
  logic               sw_en, directed;
  logic               ack_take, eoi_take, bcast_d;
  logic [NUM_VEC-1:0] post_mask, ack_mask, eoi_mask;

  assign sw_en    = |(svr_q & EN_MASK);
  assign directed = |(svr_q & DIR_MASK);

  vpc_find_top #(.WIDTH(NUM_VEC), .GROUP_W(GROUP_W)) i_irr_find (
    .bits_i (irr_q),
    .any_o  (irr_any),
    .idx_o  (irr_top)
  );

  vpc_find_top #(.WIDTH(NUM_VEC), .GROUP_W(GROUP_W)) i_isr_find (
    .bits_i (isr_q),
    .any_o  (isr_any),
    .idx_o  (isr_top)
  );

  vpc_prio_calc #(.VEC_W(VEC_W), .SUB_W(SUB_W)) i_prio (
    .enable_i  (sw_en),
    .tpr_i     (tpr_q),
    .isr_any_i (isr_any),
    .isr_cls_i (isr_top[VEC_W-1 -: CLS_W]),
    .irr_any_i (irr_any),
    .irr_cls_i (irr_top[VEC_W-1 -: CLS_W]),
    .ppr_o     (ppr),
    .blocked_o (blocked),
    .pending_o (pending)
  );

  assign ack_take = ack_i && pending;
  assign eoi_take = eoi_i && isr_any;

  assign post_mask = post_i   ? (NUM_VEC'(1) << post_vec_i) : '0;
  assign ack_mask  = ack_take ? (NUM_VEC'(1) << irr_top)    : '0;
  assign eoi_mask  = eoi_take ? (NUM_VEC'(1) << isr_top)    : '0;

  // post wins over a same-cycle acknowledge of the same vector
  assign irr_d = (irr_q & ~ack_mask) | post_mask;
  assign isr_d = (isr_q & ~eoi_mask) | ack_mask;

  always_comb begin
    tmr_d = tmr_q;
    if (post_i) begin
      if (trig_e'(post_level_i) == TRIG_LEVEL) tmr_d = tmr_q | post_mask;
      else                                     tmr_d = tmr_q & ~post_mask;
    end
  end

  assign bcast_d = eoi_take && tmr_q[isr_top] && !directed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q       <= '0;
      isr_q       <= '0;
      tmr_q       <= '0;
      tpr_q       <= '0;
      svr_q       <= '0;
      bcast_q     <= 1'b0;
      bcast_vec_q <= '0;
    end else begin
      irr_q   <= irr_d;
      isr_q   <= isr_d;
      tmr_q   <= tmr_d;
      bcast_q <= bcast_d;
      if (eoi_take)  bcast_vec_q <= isr_top;
      if (tpr_we_i)  tpr_q <= tpr_i;
      if (svr_we_i)  svr_q <= svr_i & KEEP_MASK;
    end
  end

  assign irq_o       = pending;
  assign ack_vec_o   = pending ? irr_top : svr_q[VEC_W-1:0];
  assign eoi_bcast_o = bcast_q;
  assign eoi_vec_o   = bcast_vec_q;

  assert_post_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_i |=> irr_q[$past(post_vec_i)] && (tmr_q[$past(post_vec_i)] == $past(post_level_i)));

  assert_ack_moves_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && !post_i) |=> !irr_q[$past(ack_vec_o)] && isr_q[$past(ack_vec_o)]);

  assert_collide_keeps_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && post_i && post_vec_i == ack_vec_o)
      |=> irr_q[$past(post_vec_i)] && isr_q[$past(post_vec_i)]);

  assert_blocked_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o && !post_i && !eoi_i) |=> $stable(irr_q) && $stable(isr_q));

  assert_irq_above_ppr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ppr == '0) || (ack_vec_o[VEC_W-1 -: CLS_W] > ppr[VEC_W-1 -: CLS_W]));

  assert_disable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svr_we_i && !svr_i[SVR_EN_BIT]) |=> !irq_o);

  assert_eoi_empty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && isr_q == '0 && !ack_i) |=> !eoi_bcast_o && $stable(isr_q));

  assert_bcast_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_bcast_o |-> $past(eoi_i) && !isr_q[eoi_vec_o]);
endmodule

// File: tb/test_vec_prio_core.sv
module test_vec_prio_core;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        post_i = 1'b0;
  logic [7:0]  post_vec_i = '0;
  logic        post_level_i = 1'b0;
  logic        tpr_we_i = 1'b0;
  logic [7:0]  tpr_i = '0;
  logic        svr_we_i = 1'b0;
  logic [15:0] svr_i = '0;
  logic        ack_i = 1'b0;
  logic        eoi_i = 1'b0;
  logic        irq_o;
  logic [7:0]  ack_vec_o;
  logic        eoi_bcast_o;
  logic [7:0]  eoi_vec_o;

  int n_cmp = 0;
  int n_bad = 0;

  bit [255:0] m_irr = '0;
  bit [255:0] m_isr = '0;
  bit [255:0] m_tmr = '0;
  int         m_tpr = 0;
  int         m_svr = 0;

  always #10 clk = ~clk;

  vec_prio_core i_vec_prio_core (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .post_i       (post_i),
    .post_vec_i   (post_vec_i),
    .post_level_i (post_level_i),
    .tpr_we_i     (tpr_we_i),
    .tpr_i        (tpr_i),
    .svr_we_i     (svr_we_i),
    .svr_i        (svr_i),
    .ack_i        (ack_i),
    .eoi_i        (eoi_i),
    .irq_o        (irq_o),
    .ack_vec_o    (ack_vec_o),
    .eoi_bcast_o  (eoi_bcast_o),
    .eoi_vec_o    (eoi_vec_o)
  );

  function automatic int top_of(bit [255:0] a);
    for (int i = 255; i >= 0; i--) if (a[i]) return i;
    return -1;
  endfunction

  function automatic int m_ppr();
    int t = top_of(m_isr);
    int c = (t < 0) ? 0 : (t >> 4);
    return ((m_tpr >> 4) >= c) ? m_tpr : (c << 4);
  endfunction

  function automatic bit m_pend();
    int t = top_of(m_irr);
    int p;
    if (((m_svr >> 8) & 1) == 0 || t < 0) return 1'b0;
    p = m_ppr();
    if (p != 0 && (t >> 4) <= (p >> 4)) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_post(input int v, input bit lvl, input string req);
    post_i = 1'b1; post_vec_i = 8'(v); post_level_i = lvl;
    step();
    post_i = 1'b0;
    m_irr[v] = 1'b1; m_tmr[v] = lvl;
    chk(req, 32'(irq_o), 32'(m_pend()));
  endtask

  task automatic do_tpr(input int v);
    tpr_we_i = 1'b1; tpr_i = 8'(v);
    step();
    tpr_we_i = 1'b0;
    m_tpr = v;
    chk("R13 irq after tpr write", 32'(irq_o), 32'(m_pend()));
  endtask

  task automatic do_svr(input int v);
    svr_we_i = 1'b1; svr_i = 16'(v);
    step();
    svr_we_i = 1'b0;
    m_svr = v & 'h1ff;
    chk("R13 irq after svr write", 32'(irq_o), 32'(m_pend()));
  endtask

  task automatic do_ack(input string req);
    bit p;
    int t;
    ack_i = 1'b1;
    #1;
    p = m_pend();
    t = top_of(m_irr);
    chk(req, 32'(ack_vec_o), p ? t : (m_svr & 'hff));
    step();
    ack_i = 1'b0;
    if (p) begin
      m_irr[t] = 1'b0;
      m_isr[t] = 1'b1;
    end
    chk(req, 32'(irq_o), 32'(m_pend()));
  endtask

  task automatic do_eoi(input string req);
    int t = top_of(m_isr);
    bit b = (t >= 0) && m_tmr[t] && (((m_svr >> 12) & 1) == 0);
    eoi_i = 1'b1;
    step();
    eoi_i = 1'b0;
    chk(req, 32'(eoi_bcast_o), 32'(b));
    if (b) chk(req, 32'(eoi_vec_o), t);
    if (t >= 0) m_isr[t] = 1'b0;
    chk(req, 32'(irq_o), 32'(m_pend()));
    step();
    chk("R9 pulse one cycle", 32'(eoi_bcast_o), 0);
  endtask

  task automatic drain();
    for (int k = 0; k < 600; k++) begin
      if (m_pend()) do_ack("R7 drain");
      else if (top_of(m_isr) >= 0) do_eoi("R8 drain");
      else break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", 32'(irq_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 ack_vec", 32'(ack_vec_o), 0);
    chk("R1 bcast", 32'(eoi_bcast_o), 0);
    do_post('h40, 1'b0, "R1 disabled after reset");
    chk("R1 irq stays low", 32'(irq_o), 0);

    // R13: enabling exposes the held request
    do_svr('h1ff);
    chk("R13 irq rises", 32'(irq_o), 1);
    do_ack("R3 ack held vector");
    do_eoi("R8 edge retire");

    // R2 R3 R7 R8 R9: every vector alone
    for (int v = 0; v < 256; v++) begin
      do_post(v, v[0], "R2 single post");
      chk("R2 irq single", 32'(irq_o), 1);
      do_ack("R3 single ack");
      do_eoi("R9 single eoi");
    end

    // R3: winner order with nested service
    do_post('h17, 1'b1, "R2 stack");
    do_post('hA2, 1'b1, "R2 stack");
    do_post('h64, 1'b0, "R2 stack");
    do_ack("R3 top A2");
    do_ack("R5 nested blocked");
    do_eoi("R9 retire A2");
    do_ack("R3 next 64");
    do_eoi("R9 retire 64 edge");
    do_ack("R3 last 17");
    do_eoi("R9 retire 17");

    // R4 R5: task priority against every request class
    for (int t = 0; t < 16; t++) begin
      for (int l = 0; l < 2; l++) begin
        for (int c = 0; c < 16; c++) begin
          do_tpr((t << 4) | (l ? 9 : 0));
          do_post((c << 4) | 7, 1'b0, "R5 class sweep");
          do_ack("R5 class sweep ack");
          do_tpr(0);
          drain();
        end
      end
    end

    // R4: in-service class overrides a lower task priority
    do_post('h45, 1'b1, "R4 setup");
    do_ack("R4 take 45");
    do_post('h43, 1'b1, "R4 same class blocked");
    chk("R4 blocked by isr class", 32'(irq_o), 0);
    do_post('h52, 1'b1, "R4 higher class");
    do_tpr('h60);
    chk("R4 tpr above isr", 32'(irq_o), 0);
    do_tpr('h20);
    chk("R4 isr above tpr", 32'(irq_o), 1);
    do_ack("R4 take 52");
    do_eoi("R8 retire 52");
    do_eoi("R8 retire 45");
    do_eoi("R10 empty eoi");
    do_tpr(0);
    drain();
    do_eoi("R10 empty eoi again");

    // R6: disabled ack moves nothing
    do_svr('h0f3);
    do_post('h80, 1'b1, "R6 disabled post");
    chk("R6 irq low", 32'(irq_o), 0);
    do_ack("R6 disabled ack");
    do_svr('h1f3);
    chk("R6 request kept", 32'(irq_o), 1);
    do_ack("R6 ack after enable");
    do_eoi("R6 retire");

    // R11: bit 12 dropped, high bits dropped
    do_svr('hf1e0);
    do_post('h90, 1'b1, "R11 level post");
    do_ack("R11 ack");
    do_post('h91, 1'b0, "R11 blocked post");
    do_ack("R11 spurious low byte");
    do_eoi("R11 level still broadcasts");
    drain();

    // R12: post and ack of the same vector in one cycle
    do_post('hC4, 1'b1, "R12 setup");
    post_i = 1'b1; post_vec_i = 8'hC4; post_level_i = 1'b1; ack_i = 1'b1;
    #1;
    chk("R12 ack vector", 32'(ack_vec_o), 'hC4);
    step();
    post_i = 1'b0; ack_i = 1'b0;
    m_isr['hC4] = 1'b1;
    chk("R12 blocked by own service", 32'(irq_o), 0);
    do_eoi("R12 retire");
    chk("R12 request survived", 32'(irq_o), 1);
    do_ack("R12 second ack");
    do_eoi("R12 final retire");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule